// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. Four inputs drive it: a test clock, a mode-select line, a serial data input and an asynchronous active-low test reset. It has one serial data output. A sixteen-state controller advances on each rising test-clock edge according to mode select. It steps a four-bit instruction register and a set of data registers through their capture, shift and update phases.

The active instruction chooses which data register sits between the serial input and the serial output. There are three data registers. The first is a one-bit bypass stage. The second is a 32-bit identification register whose captured value is fixed. The third is a boundary chain of parameterised length that samples a parallel pin vector and presents an updated parallel vector. The serial output changes only on falling test-clock edges. A separate enable marks the cycles in which it is actively driven.

Top module: `scan_port`

## Requirements
- R1: A low level on `trst_n` forces the controller into test-logic-reset at once, without a clock edge. `tdo_en` then drops to 0 and the active instruction becomes identification.
- R2: Five consecutive rising edges with `tms` high bring the controller to test-logic-reset from any state. It stays there while `tms` remains high.
- R3: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads the pattern 0001, so the first bit seen on `tdo` during an instruction scan is 1, followed by three 0 bits.
- R4: Opcode 0010 selects the identification register. Each Capture-DR loads 0x861A0013, which is shifted out least significant bit first. Bits shifted in on `tdi` never alter what the next capture returns.
- R5: Opcode 1111, which is what an instruction scan of all ones produces, selects the one-bit bypass stage. Capture loads 0. The data appears on `tdo` one shift later, without inversion.
- R6: Every opcode from 0011 to 1110 behaves exactly like bypass.
- R7: Opcodes 0000 and 0001 select the boundary chain of `BND_LEN` cells. Capture loads `bnd_in`, which is shifted out from bit 0 upward. Data shifted in reappears at `tdo` after `BND_LEN` shifts, without inversion.
- R8: Update-DR copies the boundary chain to `bnd_out` only while the boundary chain is selected; otherwise `bnd_out` holds. `bnd_drive` is 1 exactly while the active opcode is 0000.
- R9: `tdo` and `tdo_en` change only on falling edges of `tck`. `tdo_en` is 1 only during Shift-IR and Shift-DR.
- R10: Entering test-logic-reset loads the identification opcode 0010 as the active instruction. The active instruction otherwise changes only in Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data input, sampled on rising `tck` |
| bnd_in | input | BND_LEN | Parallel values captured into the boundary chain |
| tdo | output | 1 | Serial data output, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` is actively driven (shift states) |
| bnd_out | output | BND_LEN | Parallel values loaded from the chain at Update-DR |
| bnd_drive | output | 1 | High while the external-test opcode is active |

## Verification
The bench builds the block with its default sizes: a 150-cell boundary chain and identification value 0x861A0013. At that length, a scan of 158 bits shows the whole captured pin vector and then the first eight shifted-in bits coming back out. The same scan leaves a known pattern to compare against `bnd_out`. Random walks of the controller end with five high mode-select bits and prove recovery from arbitrary states. Every reserved opcode is loaded in turn and compared with bypass.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_EXT = 4'b0000;
  localparam logic [IR_W-1:0] OP_SMP = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDC = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYP = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
endpackage

// File: rtl/tap_ctrl_fsm.sv
module tap_ctrl_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st
);
  tap_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= TS_RESET;
    else         st <= nxt;
  end

  // R2
  tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TS_RESET && tms) |=> (st == TS_RESET));
endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      st,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so,
  output logic            sel_bnd,
  output logic            sel_id,
  output logic            sel_byp,
  output logic            ext_mode
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_IDC;
    end else begin
      case (st)
        TS_CAP_IR: ir_sh <= IR_CAPTURE;
        TS_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        default:   ir_sh <= ir_sh;
      endcase
      if (st == TS_RESET)       ir_q <= OP_IDC;
      else if (st == TS_UPD_IR) ir_q <= ir_sh;
    end
  end

  assign ir_so = ir_sh[0];

  always_comb begin
    ext_mode = (ir_q == OP_EXT);
    sel_bnd  = (ir_q == OP_EXT) || (ir_q == OP_SMP);
    sel_id   = (ir_q == OP_IDC);
    sel_byp  = !(sel_bnd || sel_id);
  end

  // R10
  ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(st == TS_UPD_IR || st == TS_RESET) |=> $stable(ir_q));
endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs
  import tap_pkg::*;
#(
  parameter int          BND_LEN  = 150,
  parameter logic [31:0] ID_VALUE = 32'h861A0013
)(
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  tap_state_e         st,
  input  logic               sel_bnd,
  input  logic               sel_id,
  input  logic               sel_byp,
  input  logic               ext_mode,
  input  logic [BND_LEN-1:0] bnd_in,
  output logic               dr_so,
  output logic [BND_LEN-1:0] bnd_out,
  output logic               bnd_drive
);
  localparam int ID_W = $bits(ID_VALUE);

  logic               byp_q;
  logic [ID_W-1:0]    id_sh;
  logic [BND_LEN-1:0] bnd_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q   <= 1'b0;
      id_sh   <= ID_VALUE;
      bnd_sh  <= '0;
      bnd_out <= '0;
    end else begin
      if (st == TS_CAP_DR) begin
        if (sel_byp) byp_q  <= 1'b0;
        if (sel_id)  id_sh  <= ID_VALUE;
        if (sel_bnd) bnd_sh <= bnd_in;
      end else if (st == TS_SHF_DR) begin
        if (sel_byp) byp_q  <= tdi;
        if (sel_id)  id_sh  <= {tdi, id_sh[ID_W-1:1]};
        if (sel_bnd) bnd_sh <= {tdi, bnd_sh[BND_LEN-1:1]};
      end
      if (st == TS_UPD_DR && sel_bnd) bnd_out <= bnd_sh;
    end
  end

  always_comb begin
    if (sel_bnd)     dr_so = bnd_sh[0];
    else if (sel_id) dr_so = id_sh[0];
    else             dr_so = byp_q;
  end

  assign bnd_drive = ext_mode;

  // R8
  bnd_out_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(st == TS_UPD_DR && sel_bnd) |=> $stable(bnd_out));
endmodule

// File: rtl/scan_port.sv
module scan_port
  import tap_pkg::*;
#(
  parameter int          BND_LEN  = 150,
  parameter logic [31:0] ID_VALUE = 32'h861A0013
)(
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BND_LEN-1:0] bnd_in,
  output logic               tdo,
  output logic               tdo_en,
  output logic [BND_LEN-1:0] bnd_out,
  output logic               bnd_drive
);
  tap_state_e      st;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, dr_so, serial_out;
  logic            sel_bnd, sel_id, sel_byp, ext_mode;

  tap_ctrl_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st)
  );

  tap_instr_reg u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st),
    .ir_q(ir_q), .ir_so(ir_so),
    .sel_bnd(sel_bnd), .sel_id(sel_id), .sel_byp(sel_byp), .ext_mode(ext_mode)
  );

  tap_data_regs #(.BND_LEN(BND_LEN), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st),
    .sel_bnd(sel_bnd), .sel_id(sel_id), .sel_byp(sel_byp), .ext_mode(ext_mode),
    .bnd_in(bnd_in), .dr_so(dr_so), .bnd_out(bnd_out), .bnd_drive(bnd_drive)
  );

  assign serial_out = (st == TS_SHF_IR) ? ir_so : dr_so;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= serial_out;
      tdo_en <= (st == TS_SHF_IR) || (st == TS_SHF_DR);
    end
  end

  // R9
  tdo_en_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (st == TS_SHF_IR || st == TS_SHF_DR));
  // R6
  sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot({sel_bnd, sel_id, sel_byp}));
  // R8
  drive_sel_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bnd_drive |-> (sel_bnd && !sel_id));
  // R10
  reset_idsel_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TS_RESET) |=> sel_id);
endmodule

// File: tb/sim_scan_port.sv
`timescale 1ns/1ps
module sim_scan_port;
  localparam int          BL  = 150;
  localparam logic [31:0] IDV = 32'h861A0013;
  localparam int          VW  = 192;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic [BL-1:0] bnd_in = '0;
  logic          tdo, tdo_en, bnd_drive;
  logic [BL-1:0] bnd_out;

  int n_chk = 0, n_bad = 0, edge_err = 0, en_err = 0;
  bit done = 0;

  always #4 tck = ~tck;

  scan_port #(.BND_LEN(BL), .ID_VALUE(IDV)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bnd_in(bnd_in),
    .tdo(tdo), .tdo_en(tdo_en), .bnd_out(bnd_out), .bnd_drive(bnd_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one tck cycle; tdo sampled before the rising edge, must not move at it (R9)
  task automatic step(input bit m, input bit d, output bit o);
    tms = m; tdi = d;
    #1;
    o = tdo;
    @(posedge tck); #1;
    if (tdo !== o) edge_err++;
    @(negedge tck); #1;
  endtask

  task automatic idle_step();
    bit x;
    step(1'b0, 1'b0, x);
  endtask

  task automatic ir_scan(input logic [3:0] op, output logic [3:0] got);
    bit x;
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 4; i++) begin
      if (tdo_en !== 1'b1) en_err++;
      step(i == 3, op[i], x);
      got[i] = x;
    end
    step(1, 0, x); step(0, 0, x);
    if (tdo_en !== 1'b0) en_err++;
  endtask

  task automatic dr_scan(input int n, input logic [VW-1:0] di, output logic [VW-1:0] dq);
    bit x;
    dq = '0;
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < n; i++) begin
      if (tdo_en !== 1'b1) en_err++;
      step(i == n-1, di[i], x);
      dq[i] = x;
    end
    step(1, 0, x); step(0, 0, x);
    if (tdo_en !== 1'b0) en_err++;
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] byp_expect(input int n, input logic [VW-1:0] di);
    logic [VW-1:0] e = '0;
    for (int i = 1; i < n; i++) e[i] = di[i-1];
    return e;
  endfunction

  initial begin
    logic [3:0]    g;
    logic [VW-1:0] di, dq, ex;
    logic [BL-1:0] pins;
    bit x;
    void'($urandom(32'd2024));

    repeat (3) @(negedge tck);
    #1;
    // R1: reset state
    chk(tdo_en === 1'b0, "R1 tdo_en in reset", {191'b0, tdo_en}, '0);
    chk(bnd_drive === 1'b0, "R8 bnd_drive in reset", {191'b0, bnd_drive}, '0);
    trst_n = 1'b1;
    idle_step();

    // R10 / R4: identification after reset, twice with random tdi
    for (int k = 0; k < 2; k++) begin
      di = rnd_vec();
      dr_scan(32, di, dq);
      chk(dq[31:0] === IDV, "R4 R10 id capture", dq, {160'b0, IDV});
    end

    // R3 and R5: all ones into IR -> bypass; capture pattern 0001
    ir_scan(4'b1111, g);
    chk(g === 4'b0001, "R3 capture-IR pattern", {188'b0, g}, {188'b0, 4'b0001});
    for (int k = 0; k < 3; k++) begin
      di = rnd_vec();
      dr_scan(9 + k, di, dq);
      ex = byp_expect(9 + k, di);
      chk(dq === ex, "R5 bypass one-stage", dq, ex);
    end

    // R6: every reserved opcode behaves as bypass
    for (int op = 3; op <= 14; op++) begin
      ir_scan(op[3:0], g);
      di = rnd_vec();
      dr_scan(7, di, dq);
      ex = byp_expect(7, di);
      chk(dq === ex, $sformatf("R6 reserved op %0d", op), dq, ex);
    end

    // R7 / R8: sample opcode, capture pins, shift through, update
    pins = BL'(rnd_vec());
    bnd_in = pins;
    ir_scan(4'b0001, g);
    chk(bnd_drive === 1'b0, "R8 no drive under sample", {191'b0, bnd_drive}, '0);
    di = rnd_vec();
    dr_scan(BL + 8, di, dq);
    ex = '0; ex[BL-1:0] = pins; ex[BL +: 8] = di[7:0];
    chk(dq[BL+7:0] === ex[BL+7:0], "R7 boundary capture and pass-through", dq, ex);
    chk(bnd_out === di[8 +: BL], "R8 update under sample", {42'b0, bnd_out}, {42'b0, di[8 +: BL]});

    // R8: leave boundary, bnd_out must hold
    ir_scan(4'b0010, g);
    dr_scan(32, rnd_vec(), dq);
    chk(bnd_out === di[8 +: BL], "R8 bnd_out held when unselected", {42'b0, bnd_out}, {42'b0, di[8 +: BL]});

    // R8 / R7: external test
    ir_scan(4'b0000, g);
    chk(bnd_drive === 1'b1, "R8 drive under extest", {191'b0, bnd_drive}, {191'b0, 1'b1});
    pins = BL'(rnd_vec());
    bnd_in = pins;
    di = rnd_vec();
    dr_scan(BL, di, dq);
    chk(dq[BL-1:0] === pins, "R7 extest capture", {42'b0, dq[BL-1:0]}, {42'b0, pins});
    chk(bnd_out === di[BL-1:0], "R8 update under extest", {42'b0, bnd_out}, {42'b0, di[BL-1:0]});

    // R2: random walks then five tms-high edges
    for (int k = 0; k < 12; k++) begin
      ir_scan(4'b1111, g);
      for (int s = 0; s < 3 + ($urandom % 25); s++) step($urandom % 2, $urandom % 2, x);
      for (int s = 0; s < 5; s++) step(1, 0, x);
      for (int s = 0; s < $urandom % 3; s++) step(1, 0, x);
      idle_step();
      dr_scan(32, rnd_vec(), dq);
      chk(dq[31:0] === IDV, "R2 five-high recovery", dq, {160'b0, IDV});
    end
    chk(bnd_drive === 1'b0, "R10 extest cleared by reset state", {191'b0, bnd_drive}, '0);

    // R1: asynchronous reset in the middle of a shift
    ir_scan(4'b1111, g);
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    step(0, 1, x);
    #1 trst_n = 1'b0;
    #1;
    chk(tdo_en === 1'b0, "R1 async tdo_en drop", {191'b0, tdo_en}, '0);
    @(negedge tck); #1;
    tms = 1'b0;
    trst_n = 1'b1;
    idle_step();
    dr_scan(32, rnd_vec(), dq);
    chk(dq[31:0] === IDV, "R1 id after async reset", dq, {160'b0, IDV});

    // R9: edge behaviour and enable accumulated over all scans
    chk(edge_err == 0, "R9 tdo moved on rising edge", edge_err, 0);
    chk(en_err == 0, "R9 tdo_en outside shift", en_err, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule